// File: doc/BRIEF.md
# Inductive Reuse Input Port

This block is the receiving port between a data bus and a compute fabric. Incoming scalar elements are buffered in a small FIFO. They are then gathered, one per lane in rising lane order, into a vector group of up to the configured vector length. Each finished group is presented to the fabric a number of times that is configured per run. That count changes by a signed step after every group. This serves dependences whose reuse shrinks or grows with an outer loop, such as a value consumed n-k times.

When fewer elements remain than the vector length, the last group is partial. Its unused lanes carry zero data and a cleared predicate bit, so the fabric can treat them as switched off without stalling. A group whose current reuse count is zero or negative is retired without being shown to the fabric.

A run is set up with a single start pulse that captures the element count, the initial reuse count, the signed step and the vector length. A done flag rises once every element has been taken in and its group retired. Both sides of the port use a valid/ready handshake.

Top module: `inductive_reuse_port`

## Requirements
- R1: After reset, out_valid and done are 0 and in_ready is 1.
- R2: The buffer holds exactly 4 elements. With nothing draining it, in_ready falls to 0 after the fourth accepted element, and an element offered while in_ready is 0 is not stored.
- R3: A group is presented on consecutive handshakes exactly as many times as its reuse count. While out_valid is 1 and out_ready is 0, out_valid, out_data and out_pred hold.
- R4: The reuse count starts at the signed value on cfg_reuse_init and, after each group is retired, has the signed cfg_reuse_step added to it.
- R5: A group whose reuse count is zero or negative is retired with no handshake, and its elements are still counted as consumed.
- R6: Element j of a group (j counted from 0 in arrival order) appears on lane j, which is out_data bits [16j+15:16j], and sets out_pred bit j to 1. Lane 0 is the lowest slice.
- R7: When the remaining element count is non-zero and below the vector length, the final group fills only that many low lanes. All higher lanes carry zero data with a predicate bit of 0.
- R8: Lanes at or above the vector length are always zero with a predicate bit of 0. A cfg_vlen of 0, or one larger than the lane count of 4, is treated as 4.
- R9: done rises after all cfg_total elements have been consumed and the last group has been retired, and out_valid is 0 while done is 1. A run with cfg_total of 0 raises done on the second clock edge after the start pulse.
- R10: A start pulse loads a new configuration and clears done on the next edge.
- R11: Elements are taken only on cycles where in_valid and in_ready are both 1, and they keep their arrival order across groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures the configuration and begins a run |
| cfg_total | input | 12 | Number of elements in the run |
| cfg_reuse_init | input | 8 | Signed reuse count of the first group |
| cfg_reuse_step | input | 8 | Signed change of the reuse count after each group |
| cfg_vlen | input | 3 | Vector length in lanes (0 or above 4 means 4) |
| in_valid | input | 1 | Upstream element valid |
| in_ready | output | 1 | Buffer can accept an element |
| in_data | input | 16 | Upstream element |
| out_valid | output | 1 | A group is offered to the fabric |
| out_ready | input | 1 | Fabric takes the offered group |
| out_data | output | 64 | Four 16-bit lanes, lane 0 in the low bits |
| out_pred | output | 4 | Per-lane predicate, 1 means the lane holds an element |
| done | output | 1 | All elements consumed and the last group retired |

## Verification
The embedded properties check, on every cycle, the parts that are local: the buffer never overflows or underflows, predicate bits form a low-lane prefix no wider than the vector length, unpredicated lanes hold zero, the delivery counter stays below the reuse count, and the offered group holds under backpressure. Whether each group is shown the right number of times, whether the reuse count follows the signed step through dropped groups, whether lane order matches arrival order, and when done rises all depend on the whole sequence. Only the bench's scenarios can show those, by comparing every accepted beat against an independent model of the reuse schedule.

// File: rtl/rport_pkg.sv
package rport_pkg;

    parameter int DATA_W = 16;
    parameter int LANE_N = 4;
    parameter int CNT_W  = 12;
    parameter int RUSE_W = 8;

    localparam int VL_W   = $clog2(LANE_N + 1);
    localparam int LI_W   = $clog2(LANE_N);
    localparam int RACC_W = RUSE_W + 4;

    // Per-run settings that stay live after the start pulse
    typedef struct packed {
        logic signed [RUSE_W-1:0] reuse_step;
        logic [VL_W-1:0]          vlen;
    } lane_cfg_t;

    // One vector group as presented to the fabric
    typedef struct packed {
        logic [LANE_N-1:0]             pred;
        logic [LANE_N-1:0][DATA_W-1:0] data;
    } vec_t;

    // Out-of-range vector lengths fall back to the full lane count
    function automatic logic [VL_W-1:0] clamp_vlen(input logic [VL_W-1:0] v);
        if (v == '0 || v > VL_W'(LANE_N))
            return VL_W'(LANE_N);
        return v;
    endfunction

endpackage

// File: rtl/rport_fifo.sv
module rport_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push)
                wr_ptr <= ptr_next(wr_ptr);
            if (pop)
                rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R2
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R11
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/rport_packer.sv
module rport_packer
    import rport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  total,
    input  logic [VL_W-1:0]   vlen,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              release_grp,
    output logic              pull,
    output vec_t              grp,
    output logic              grp_full,
    output logic              drained
);

    logic [CNT_W-1:0] rem;
    logic [LI_W-1:0]  lane;
    logic             full_q;
    vec_t             grp_q;
    logic             last_in_grp;

    assign pull        = !start && !full_q && (rem != '0) && !fifo_empty;
    assign last_in_grp = ((VL_W'(lane) + VL_W'(1)) == vlen) || (rem == CNT_W'(1));
    assign grp         = grp_q;
    assign grp_full    = full_q;
    assign drained     = (rem == '0) && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            lane   <= '0;
            full_q <= 1'b0;
            grp_q  <= '0;
        end else if (start) begin
            rem    <= total;
            lane   <= '0;
            full_q <= 1'b0;
            grp_q  <= '0;
        end else if (pull) begin
            grp_q.data[lane] <= fifo_data;
            grp_q.pred[lane] <= 1'b1;
            rem              <= rem - CNT_W'(1);
            if (last_in_grp) begin
                full_q <= 1'b1;
                lane   <= '0;
            end else begin
                lane   <= lane + LI_W'(1);
            end
        end else if (full_q && release_grp) begin
            full_q <= 1'b0;
            grp_q  <= '0;
        end
    end

    // R7
    packer_pred_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_q.pred & (grp_q.pred + LANE_N'(1))) == '0);

    // R8
    packer_lane_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grp_q.pred) <= int'(vlen));

    for (genvar gi = 0; gi < LANE_N; gi++) begin : g_pad
        // R7
        packer_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !grp_q.pred[gi] |-> (grp_q.data[gi] == '0));
    end

endmodule

// File: rtl/rport_reuse.sv
module rport_reuse
    import rport_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [RUSE_W-1:0] reuse_init,
    input  logic signed [RUSE_W-1:0] reuse_step,
    input  logic                     grp_full,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic                     release_grp
);

    logic signed [RACC_W-1:0] rcur;
    logic signed [RACC_W-1:0] dcnt;
    logic signed [RACC_W-1:0] dcnt_inc;
    logic                     rpos;
    logic                     last_rep;

    assign rpos        = (rcur > 0);
    assign dcnt_inc    = dcnt + RACC_W'(1);
    assign last_rep    = (dcnt_inc == rcur);
    assign out_valid   = grp_full && rpos;
    assign release_grp = grp_full && (!rpos || (out_ready && last_rep));

    always_ff @(posedge clk) begin
        if (rst) begin
            rcur <= '0;
            dcnt <= '0;
        end else if (start) begin
            rcur <= RACC_W'(reuse_init);
            dcnt <= '0;
        end else if (release_grp) begin
            rcur <= rcur + RACC_W'(reuse_step);
            dcnt <= '0;
        end else if (out_valid && out_ready) begin
            dcnt <= dcnt_inc;
        end
    end

    // R3
    reuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> out_valid);

    // R3
    reuse_dcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dcnt < rcur));

endmodule

// File: rtl/inductive_reuse_port.sv
module inductive_reuse_port
    import rport_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [CNT_W-1:0]           cfg_total,
    input  logic [RUSE_W-1:0]          cfg_reuse_init,
    input  logic [RUSE_W-1:0]          cfg_reuse_step,
    input  logic [VL_W-1:0]            cfg_vlen,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [LANE_N*DATA_W-1:0]   out_data,
    output logic [LANE_N-1:0]          out_pred,
    output logic                       done
);

    lane_cfg_t         cfg_q;
    logic              fifo_full, fifo_empty, pull;
    logic [DATA_W-1:0] fifo_data;
    vec_t              grp;
    logic              grp_full, drained, release_grp;
    logic              active, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (start) begin
            cfg_q.reuse_step <= $signed(cfg_reuse_step);
            cfg_q.vlen       <= clamp_vlen(cfg_vlen);
        end
    end

    assign in_ready = !fifo_full;

    rport_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (in_valid && !fifo_full),
        .push_data (in_data),
        .pop       (pull),
        .pop_data  (fifo_data),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    rport_packer u_packer (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .total       (cfg_total),
        .vlen        (cfg_q.vlen),
        .fifo_empty  (fifo_empty),
        .fifo_data   (fifo_data),
        .release_grp (release_grp),
        .pull        (pull),
        .grp         (grp),
        .grp_full    (grp_full),
        .drained     (drained)
    );

    rport_reuse u_reuse (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .reuse_init  ($signed(cfg_reuse_init)),
        .reuse_step  (cfg_q.reuse_step),
        .grp_full    (grp_full),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .release_grp (release_grp)
    );

    assign out_data = grp.data;
    assign out_pred = grp.pred;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            done_q <= 1'b0;
        end else if (active && drained) begin
            active <= 1'b0;
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

    // R9
    top_done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R3
    top_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> ($stable(out_data) && $stable(out_pred)));

endmodule

// File: tb/inductive_reuse_port_tb.sv
module inductive_reuse_port_tb;
    import rport_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                     rst, start, in_valid, in_ready, out_valid, out_ready, done;
    logic [CNT_W-1:0]         cfg_total;
    logic [RUSE_W-1:0]        cfg_reuse_init, cfg_reuse_step;
    logic [VL_W-1:0]          cfg_vlen;
    logic [DATA_W-1:0]        in_data;
    logic [LANE_N*DATA_W-1:0] out_data;
    logic [LANE_N-1:0]        out_pred;

    inductive_reuse_port u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_total(cfg_total),
        .cfg_reuse_init(cfg_reuse_init), .cfg_reuse_step(cfg_reuse_step),
        .cfg_vlen(cfg_vlen), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_pred(out_pred), .done(done)
    );

    // total, reuse init, reuse step, vlen, input gap mask, output stall mask
    localparam int NCASE = 7;
    localparam int TBL [NCASE][6] = '{
        '{8, 1,  0, 4, 0, 0},
        '{6, 3, -1, 4, 0, 1},
        '{5, 1,  1, 2, 1, 0},
        '{7, 2, -1, 1, 0, 3},
        '{4, 0,  2, 3, 3, 1},
        '{5, 2,  0, 0, 0, 2},
        '{3, 1,  0, 7, 1, 1}
    };

    int checks = 0;
    int errors = 0;
    int wd_cyc = 0;

    int m_rem, m_base, m_r, m_rep, m_vl, m_step;

    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", wd_cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int tot, input int ini, input int stp, input int vl);
        cfg_total      = CNT_W'(tot);
        cfg_reuse_init = RUSE_W'(ini);
        cfg_reuse_step = RUSE_W'(stp);
        cfg_vlen       = VL_W'(vl);
        start          = 1'b1;
        @(negedge clk);
        start          = 1'b0;
    endtask

    function automatic int grp_len();
        return (m_vl < m_rem) ? m_vl : m_rem;
    endfunction

    // Retire groups whose reuse count is zero or negative (R5)
    task automatic m_settle();
        while (m_rem > 0 && m_r <= 0) begin
            int n = grp_len();
            m_base += n;
            m_rem  -= n;
            m_r    += m_step;
        end
    endtask

    task automatic check_beat(input int k);
        logic [LANE_N*DATA_W-1:0] ed;
        logic [LANE_N-1:0]        ep;
        int n;
        m_settle();
        if (m_rem == 0) begin
            checks++;
            errors++;
            $display("FAIL R3 R5 extra beat actual=%0h expected=none", out_data);
            return;
        end
        n  = grp_len();
        ed = '0;
        ep = '0;
        for (int i = 0; i < LANE_N; i++) begin
            if (i < n) begin
                ed[i*DATA_W +: DATA_W] = DATA_W'(k*256 + m_base + i);
                ep[i] = 1'b1;
            end
        end
        chk("R4 R6 R7 R11", "lane data", 64'(out_data), 64'(ed));
        chk("R7 R8", "lane predicate", 64'(out_pred), 64'(ep));
        m_rep++;
        if (m_rep >= m_r) begin
            m_base += n;
            m_rem  -= n;
            m_r    += m_step;
            m_rep   = 0;
        end
    endtask

    task automatic run_case(input int k);
        int tot, im, om, pushed;
        bit finished;
        tot = TBL[k][0];
        im  = TBL[k][4];
        om  = TBL[k][5];
        pulse_start(tot, TBL[k][1], TBL[k][2], TBL[k][3]);
        #1;
        chk("R10", "done after start", 64'(done), 64'd0);
        m_rem  = tot;
        m_base = 0;
        m_r    = TBL[k][1];
        m_rep  = 0;
        m_step = TBL[k][2];
        m_vl   = (TBL[k][3] == 0 || TBL[k][3] > LANE_N) ? LANE_N : TBL[k][3];
        pushed   = 0;
        finished = 1'b0;
        for (int cyc = 0; cyc < 3000 && !finished; cyc++) begin
            in_valid  = (pushed < tot) && ((cyc & im) == 0);
            in_data   = DATA_W'(k*256 + pushed);
            out_ready = ((cyc & om) == 0);
            #1;
            if (done) begin
                finished = 1'b1;
                m_settle();
                chk("R9", "elements left at done", 64'(m_rem), 64'd0);
                chk("R9", "out_valid at done", 64'(out_valid), 64'd0);
            end else begin
                if (in_valid && in_ready) pushed++;
                if (out_valid && out_ready) check_beat(k);
                @(negedge clk);
            end
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        if (!finished) chk("R9", "done never rose", 64'd0, 64'd1);
    endtask

    initial begin
        int acc;
        bit seen;
        rst = 1'b1; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_data = '0; cfg_total = '0; cfg_reuse_init = '0;
        cfg_reuse_step = '0; cfg_vlen = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "out_valid", 64'(out_valid), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "in_ready", 64'(in_ready), 64'd1);

        // R2 capacity: nothing drains before a start
        @(negedge clk);
        acc = 0;
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1;
            in_data  = DATA_W'(16'h0A00 + i);
            #1;
            if (in_ready) acc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        #1;
        chk("R2", "accepted count", 64'(acc), 64'd4);
        chk("R2", "in_ready when full", 64'(in_ready), 64'd0);
        @(negedge clk);
        pulse_start(4, 1, 0, 4);
        seen = 1'b0;
        out_ready = 1'b1;
        for (int c = 0; c < 20 && !seen; c++) begin
            #1;
            if (out_valid) begin
                seen = 1'b1;
                // R11 order kept, R2 fifth value never stored
                chk("R11 R2", "buffered group", 64'(out_data), 64'h0A03_0A02_0A01_0A00);
                chk("R6", "full predicate", 64'(out_pred), 64'hF);
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        if (!seen) chk("R11", "buffered group never offered", 64'd0, 64'd1);
        @(negedge clk);
        #1;
        chk("R9", "done after buffered run", 64'(done), 64'd1);
        chk("R2", "in_ready after drain", 64'(in_ready), 64'd1);

        // R9 empty run
        @(negedge clk);
        pulse_start(0, 1, 0, 4);
        #1;
        chk("R10", "done cleared by start", 64'(done), 64'd0);
        @(negedge clk);
        #1;
        chk("R9", "done for empty run", 64'(done), 64'd1);
        chk("R9", "no beat for empty run", 64'(out_valid), 64'd0);
        @(negedge clk);

        // Table of configurations
        for (int k = 0; k < NCASE; k++) begin
            run_case(k);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule